// File: doc/BRIEF.md
# Latched 16-bit serial control port

This block is the write-only configuration port of an audio DAC subsystem. A host drives three wires: a serial clock, an active-low framing line called the latch, and a data line. While the latch is low, the port takes one data bit on each rising edge of the serial clock, most significant bit first. When the latch returns high and exactly sixteen bits have arrived, the word is committed. Its two lowest bits choose the destination register.

There are four destination registers:
- a DAC control register: interpolation rate, word length, output phase, soft mute, serial format and de-emphasis;
- a left volume register;
- a right volume register;
- a clock-configuration register: three power-down flags, a clock mode and the master-clock direction.

Every field appears as a registered output in the system clock domain.

The serial clock may be gated between words or may run all the time. It is asynchronous to the system clock and runs at up to 8 MHz. All three serial wires are synchronised into the system clock domain and oversampled there. This requires the system clock to run at more than six times the serial clock rate.

Top module: `ctl_word_port`

## Requirements
- R1: A word is 16 bits. It is sampled on rising serial-clock edges while the latch is low, first bit = bit 15, and it is committed only when the latch rises.
- R2: Word bits 1:0 select the target: 01 = DAC control, 00 = left volume, 10 = right volume, 11 = clock configuration. A committed word changes no other register.
- R3: DAC control fields are:
  - bits 11:10 = interp (00 = 8x, 01 = 4x, 10 = 2x);
  - bits 9:8 = wlen;
  - bit 7 = phase_inv;
  - bit 6 = soft_mute;
  - bits 5:4 = fmt;
  - bits 3:2 = deemph (00 = none, 01 = 44.1 kHz, 10 = 32 kHz, 11 = 48 kHz).
- R4: A DAC control word whose bits 11:10 are 11 leaves interp unchanged. The other fields of that word are still written.
- R5: A volume word carries the 14-bit unsigned volume in bits 15:2.
- R6: Clock-configuration fields are:
  - pd[2:0] = bits 11:9;
  - clk_mode = bit 8;
  - mclk_in = bit 2 (0 = master clock is an output).
- R7: A frame with fewer or more than 16 rising serial-clock edges while the latch is low is discarded.
- R8: Rising serial-clock edges while the latch is high have no effect. Gated and free-running serial clocks both work.
- R9: While rst is high at a clock edge, every register takes its default: all DAC control fields 0, both volumes all ones (full volume), pd 000, clk_mode 0, mclk_in 0.
- R10: If the latch rise is first sampled at system clock edge k, the new register value appears at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial control clock, asynchronous |
| ser_latch | input | 1 | Frame line, low during a transfer |
| ser_dat | input | 1 | Serial data, MSB first |
| interp | output | 2 | Interpolation rate code |
| wlen | output | 2 | Serial word length code |
| phase_inv | output | 1 | Output phase inverted |
| soft_mute | output | 1 | Soft mute request |
| fmt | output | 2 | Serial data format code |
| deemph | output | 2 | De-emphasis selection |
| vol_l | output | VOL_W | Left volume |
| vol_r | output | VOL_W | Right volume |
| pd | output | 3 | Power-down flags |
| clk_mode | output | 1 | Clock configuration mode |
| mclk_in | output | 1 | Master-clock direction, 1 = input |

## Verification
Every result is due at the third system edge after the edge that first samples the latch rise:
- two edges for the synchroniser;
- one edge for the commit pulse;
- one edge for the register write.

The bench model holds each accepted word in a countdown. The countdown starts at four when the latch is driven high and is applied at the fourth following rising edge. All outputs are compared with the model on every falling edge. Discarded frames and ignored fields are observed as outputs that stay steady over the whole window, and they are also checked against literal values after each phase.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
  typedef enum logic [1:0] {
    ADR_VOL_L = 2'b00,
    ADR_DAC   = 2'b01,
    ADR_VOL_R = 2'b10,
    ADR_CLK   = 2'b11
  } adr_e;

  localparam logic [1:0] INTERP_BAD = 2'b11;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ctl_deser.sv
module ctl_deser #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              latch_s,
  input  logic              dat_s,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic              sclk_d;
  logic              latch_d;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              sclk_rise;
  logic              latch_rise;

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign latch_rise = latch_s & ~latch_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      latch_d  <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      latch_d  <= latch_s;
      word_vld <= latch_rise && (cnt == CNT_FULL);
      if (latch_rise) word <= shreg;
      if (latch_s) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[WORD_W-2:0], dat_s};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: the commit pulse is one cycle wide
  assert_pulse_once_R1: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
  // R1: a commit is only seen once the latch is high
  assert_commit_latched_R1: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> latch_d);
  // R7: the edge counter saturates just above a full word
  assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_OVER);
  // R8: the counter stays cleared while the latch is high
  assert_idle_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (latch_s && $past(latch_s)) |-> (cnt == '0));
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctlp_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int VOL_W = WORD_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  output logic [1:0]        interp,
  output logic [1:0]        wlen,
  output logic              phase_inv,
  output logic              soft_mute,
  output logic [1:0]        fmt,
  output logic [1:0]        deemph,
  output logic [VOL_W-1:0]  vol_l,
  output logic [VOL_W-1:0]  vol_r,
  output logic [2:0]        pd,
  output logic              clk_mode,
  output logic              mclk_in
);
  adr_e adr;
  assign adr = adr_e'(word[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      interp    <= '0;
      wlen      <= '0;
      phase_inv <= 1'b0;
      soft_mute <= 1'b0;
      fmt       <= '0;
      deemph    <= '0;
      vol_l     <= '1;
      vol_r     <= '1;
      pd        <= '0;
      clk_mode  <= 1'b0;
      mclk_in   <= 1'b0;
    end else if (word_vld) begin
      case (adr)
        ADR_DAC: begin
          if (word[11:10] != INTERP_BAD) interp <= word[11:10];
          wlen      <= word[9:8];
          phase_inv <= word[7];
          soft_mute <= word[6];
          fmt       <= word[5:4];
          deemph    <= word[3:2];
        end
        ADR_VOL_L: vol_l <= word[WORD_W-1:2];
        ADR_VOL_R: vol_r <= word[WORD_W-1:2];
        default: begin
          pd       <= word[11:9];
          clk_mode <= word[8];
          mclk_in  <= word[2];
        end
      endcase
    end
  end

  // R4: the illegal interpolation code never reaches the output
  assert_interp_legal_R4: assert property (@(posedge clk) disable iff (rst)
    interp != INTERP_BAD);
  // R2: without a commit no register moves
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !word_vld |=> $stable({interp, wlen, phase_inv, soft_mute, fmt, deemph,
                           vol_l, vol_r, pd, clk_mode, mclk_in}));
  // R2: a volume commit leaves the DAC control fields alone
  assert_vol_isolated_R2: assert property (@(posedge clk) disable iff (rst)
    (word_vld && word[0] == 1'b0) |=> $stable({interp, wlen, phase_inv,
                                               soft_mute, fmt, deemph}));
  // R9: defaults follow a reset cycle
  assert_defaults_R9: assert property (@(posedge clk)
    $past(rst) |-> (interp == 2'b00 && vol_l == '1 && vol_r == '1 &&
                    pd == 3'b000 && !clk_mode && !mclk_in && !soft_mute));
endmodule

// File: rtl/ctl_word_port.sv
module ctl_word_port #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 16,
  localparam int VOL_W      = WORD_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_latch,
  input  logic             ser_dat,
  output logic [1:0]       interp,
  output logic [1:0]       wlen,
  output logic             phase_inv,
  output logic             soft_mute,
  output logic [1:0]       fmt,
  output logic [1:0]       deemph,
  output logic [VOL_W-1:0] vol_l,
  output logic [VOL_W-1:0] vol_r,
  output logic [2:0]       pd,
  output logic             clk_mode,
  output logic             mclk_in
);
  logic [2:0]        pins_s;
  logic              word_vld;
  logic [WORD_W-1:0] word;

  ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_clk, ser_latch, ser_dat}),
    .q   (pins_s)
  );

  ctl_deser #(.WORD_W(WORD_W)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (pins_s[2]),
    .latch_s  (pins_s[1]),
    .dat_s    (pins_s[0]),
    .word_vld (word_vld),
    .word     (word)
  );

  ctl_regfile #(.WORD_W(WORD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .word_vld  (word_vld),
    .word      (word),
    .interp    (interp),
    .wlen      (wlen),
    .phase_inv (phase_inv),
    .soft_mute (soft_mute),
    .fmt       (fmt),
    .deemph    (deemph),
    .vol_l     (vol_l),
    .vol_r     (vol_r),
    .pd        (pd),
    .clk_mode  (clk_mode),
    .mclk_in   (mclk_in)
  );
endmodule

// File: tb/ctl_word_port_bench.sv
`timescale 1ns/1ps
module ctl_word_port_bench;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_latch = 1'b1;
  logic ser_dat = 1'b0;
  logic [1:0] interp, wlen, fmt, deemph;
  logic phase_inv, soft_mute, clk_mode, mclk_in;
  logic [13:0] vol_l, vol_r;
  logic [2:0] pd;

  always #10 clk = ~clk;

  ctl_word_port u_ctl_word_port (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_latch(ser_latch),
    .ser_dat(ser_dat), .interp(interp), .wlen(wlen), .phase_inv(phase_inv),
    .soft_mute(soft_mute), .fmt(fmt), .deemph(deemph), .vol_l(vol_l),
    .vol_r(vol_r), .pd(pd), .clk_mode(clk_mode), .mclk_in(mclk_in)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R9";

  // reference model state
  logic [1:0] m_interp, m_wlen, m_fmt, m_deemph;
  logic m_phase, m_mute, m_mode, m_mclk;
  logic [13:0] m_vl, m_vr;
  logic [2:0] m_pd;
  logic [15:0] pend_w;
  int cd = 0;

  task automatic m_defaults();
    m_interp = 0; m_wlen = 0; m_fmt = 0; m_deemph = 0;
    m_phase = 0; m_mute = 0; m_mode = 0; m_mclk = 0;
    m_vl = '1; m_vr = '1; m_pd = 0;
  endtask

  task automatic m_apply(input logic [15:0] w);
    case (w[1:0])
      2'b01: begin
        if (w[11:10] != 2'b11) m_interp = w[11:10];
        m_wlen = w[9:8]; m_phase = w[7]; m_mute = w[6];
        m_fmt = w[5:4]; m_deemph = w[3:2];
      end
      2'b00: m_vl = w[15:2];
      2'b10: m_vr = w[15:2];
      default: begin m_pd = w[11:9]; m_mode = w[8]; m_mclk = w[2]; end
    endcase
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_defaults();
      cd = 0;
      started = 1;
    end else if (cd > 0) begin
      cd--;
      if (cd == 0) m_apply(pend_w);
    end
  end

  task automatic cmp(input string tag);
    checks++;
    if ({interp, wlen, phase_inv, soft_mute, fmt, deemph, vol_l, vol_r, pd, clk_mode, mclk_in} !==
        {m_interp, m_wlen, m_phase, m_mute, m_fmt, m_deemph, m_vl, m_vr, m_pd, m_mode, m_mclk}) begin
      errors++;
      $display("FAIL %s/R10 at cycle %0d: got i%h w%h p%b m%b f%h d%h L%h R%h pd%b c%b k%b exp i%h w%h p%b m%b f%h d%h L%h R%h pd%b c%b k%b",
        tag, cyc, interp, wlen, phase_inv, soft_mute, fmt, deemph, vol_l, vol_r, pd, clk_mode, mclk_in,
        m_interp, m_wlen, m_phase, m_mute, m_fmt, m_deemph, m_vl, m_vr, m_pd, m_mode, m_mclk);
    end
  endtask

  always @(negedge clk) if (started && !done) cmp(cur_req);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clk();
    ser_clk = 1'b1; wait_n(HP); ser_clk = 1'b0; wait_n(HP);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input bit extra);
    if (extra) begin ser_dat = 1'b1; repeat (3) pulse_clk(); end
    ser_latch = 1'b0; wait_n(HP);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 16) ? w[15-i] : 1'b0;
      wait_n(HP);
      ser_clk = 1'b1; wait_n(HP); ser_clk = 1'b0;
    end
    wait_n(HP);
    ser_latch = 1'b1;
    if (nbits == 16) begin pend_w = w; cd = 4; end
    if (extra) begin ser_dat = 1'b1; repeat (3) pulse_clk(); end
    wait_n(12);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(2);
    cur_req = "R9";
    chk("R9 interp", 32'(interp), 0);
    chk("R9 vol_l", 32'(vol_l), 32'h3FFF);
    chk("R9 vol_r", 32'(vol_r), 32'h3FFF);
    chk("R9 clkcfg", 32'({pd, clk_mode, mclk_in}), 0);

    cur_req = "R3";
    send(16'h06F9, 16, 0);
    chk("R1/R3 dac", 32'({interp, wlen, phase_inv, soft_mute, fmt, deemph}), 32'b01_10_1_1_11_10);

    cur_req = "R5";
    send(16'h48D0, 16, 0);
    send(16'hAAAA, 16, 0);
    chk("R5 vol_l", 32'(vol_l), 32'h1234);
    chk("R5 vol_r", 32'(vol_r), 32'h2AAA);
    chk("R2 dac kept", 32'({interp, wlen, phase_inv, soft_mute, fmt, deemph}), 32'b01_10_1_1_11_10);

    cur_req = "R6";
    send(16'h0B07, 16, 0);
    chk("R6 pd", 32'(pd), 32'b101);
    chk("R6 mode/mclk", 32'({clk_mode, mclk_in}), 32'b11);
    chk("R2 vols kept", 32'({vol_l, vol_r}), {4'h0, 14'h1234, 14'h2AAA});

    cur_req = "R4";
    send(16'h0D0D, 16, 0);
    chk("R4 interp held", 32'(interp), 32'b01);
    chk("R4 other fields", 32'({wlen, phase_inv, soft_mute, fmt, deemph}), 32'b01_0_0_00_11);

    cur_req = "R7";
    send(16'hFFF8, 15, 0);
    chk("R7 short frame", 32'(vol_l), 32'h1234);
    send(16'h0000, 17, 0);
    chk("R7 long frame", 32'(vol_l), 32'h1234);

    cur_req = "R8";
    send(16'h0556, 16, 1);
    chk("R8 free-running clock", 32'(vol_r), 32'h0155);
    chk("R8 left kept", 32'(vol_l), 32'h1234);

    cur_req = "R9";
    rst = 1'b1; wait_n(2); rst = 1'b0; wait_n(1);
    chk("R9 vol_l after reset", 32'(vol_l), 32'h3FFF);
    chk("R9 interp after reset", 32'(interp), 0);
    chk("R9 pd after reset", 32'(pd), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule